// File: doc/BRIEF.md
# Single-wire slave edge glitch filter

This block sits between the pin of an open-drain single-wire bus and the time-slot logic of a slave. It brings the raw line into the clock domain through a two-stage synchronizer. A small state machine then decides which falling edges are real slot starts. For each accepted falling edge it emits a one-cycle `slot_start` strobe. It also drives a cleaned line level, `line_clean`, that downstream logic can sample instead of the noisy pin.

The state machine advances only on cycles where `tick` is high, so every length below is counted in ticks. Two rules shape its behaviour. At standard speed a falling edge is accepted only after the line has stayed low for `FLT_STD` consecutive tick samples. In overdrive (`od_mode` = 1) the first low sample is enough. After the cleaned line returns high, a hold-off window of `HOLD_STD` or `HOLD_OD` ticks (chosen by `od_mode`) ignores low-going glitches, at both speeds. A low that is still present on the last tick of the window is taken as a new slot start at once.

States: `ST_IDLE` (line high, waiting), `ST_QUAL` (standard-speed low being qualified), `ST_LOW` (accepted low, cleaned line low), `ST_HOLD` (hold-off window). Transitions: IDLE to LOW on a low sample in overdrive (accept); IDLE to QUAL on a low sample at standard speed; QUAL to IDLE on a high sample (reject); QUAL to LOW on the `FLT_STD`-th consecutive low sample (accept); LOW to HOLD on a high sample (rise); HOLD to LOW on the last window tick with the line low (late accept); HOLD to IDLE on the last window tick with the line high (expire).

Top module: `swire_edge_filter`

## Requirements
- R1: While reset is asserted and directly after it, `line_clean` is 1 and `slot_start` is 0. No hold-off window is active, and the synchronizer holds the high level.
- R2: At standard speed, a low lasting at least `FLT_STD` consecutive tick samples is accepted. With `tick` high every cycle, the strobe is seen `FLT_STD`+2 cycles after the raw line falls. A shorter low gives no strobe.
- R3: In overdrive, the first low tick sample is accepted. With `tick` high every cycle, the strobe is seen 3 cycles after the raw line falls.
- R4: `line_clean` falls in the same cycle as `slot_start`. It stays 0 until a high synchronized sample is taken on a tick, and it is 1 from the cycle after that edge.
- R5: On the rise of `line_clean`, a hold-off window of H ticks opens, with H = `HOLD_OD` in overdrive and `HOLD_STD` otherwise. Low samples on the first H-1 ticks of the window give no strobe and leave `line_clean` at 1.
- R6: If the sample on the last window tick is low, a strobe is given on that tick with no further filtering. With `tick` high every cycle, this is H+3 cycles after the raw line rose.
- R7: Once the window has expired, falling edges are filtered again as in R2 or R3, according to `od_mode`.
- R8: `slot_start` is exactly one cycle wide and occurs once per accepted falling edge.
- R9: On cycles with `tick` low, the state machine holds its state, `slot_start` stays 0 and `line_clean` does not change.
- R10: The raw line passes through two synchronizer flops before any filtering, which accounts for two cycles of every latency above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for the filter state machine |
| od_mode | input | 1 | 1 = overdrive speed, 0 = standard speed |
| line_raw | input | 1 | Raw bus line level, asynchronous |
| line_clean | output | 1 | Filtered line level |
| slot_start | output | 1 | One-cycle strobe per accepted falling edge |

## Verification
The assertions rely on both lengths being at least 2 ticks, so a rise can never be followed by a strobe on the next tick. They also assume `tick` is the only gate on state changes. The stimulus changes `od_mode` only while the line has been high and idle long enough for any window to have expired. It uses the default lengths throughout. The raw line is driven on falling clock edges, so every expected strobe cycle follows from the stated latencies.

// File: rtl/swef_pkg.sv
package swef_pkg;

    // Filter state machine states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // line high, waiting for a fall
        ST_QUAL = 2'd1,  // standard-speed low under qualification
        ST_LOW  = 2'd2,  // accepted low, cleaned line is low
        ST_HOLD = 2'd3   // hold-off window after a rise
    } swef_state_t;

    function automatic int swef_max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/swef_sync.sv
module swef_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_LEVEL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= RST_LEVEL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/swef_limits.sv
module swef_limits #(
    parameter int FLT_STD  = 4,
    parameter int HOLD_STD = 8,
    parameter int HOLD_OD  = 3,
    parameter int CW       = 4
) (
    input  logic          od_mode,
    output logic [CW-1:0] flt_last,
    output logic [CW-1:0] hold_last
);

    // Terminal counter values: count runs 0..N-1
    localparam logic [CW-1:0] FLT_LAST_C  = CW'(FLT_STD - 1);
    localparam logic [CW-1:0] HSTD_LAST_C = CW'(HOLD_STD - 1);
    localparam logic [CW-1:0] HOD_LAST_C  = CW'(HOLD_OD - 1);

    always_comb begin
        flt_last  = FLT_LAST_C;
        hold_last = od_mode ? HOD_LAST_C : HSTD_LAST_C;
    end

endmodule

// File: rtl/swef_fsm.sv
module swef_fsm
    import swef_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          od_mode,
    input  logic          line_s,
    input  logic [CW-1:0] flt_last,
    input  logic [CW-1:0] hold_last,
    output logic          line_clean,
    output logic          slot_start
);

    localparam logic [CW-1:0] ONE = CW'(1);

    swef_state_t st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic accept;

    // Next-state and counter logic
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        accept = 1'b0;
        if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!line_s) begin
                        if (od_mode) begin
                            accept = 1'b1;
                            st_n   = ST_LOW;
                            cnt_n  = '0;
                        end else begin
                            st_n  = ST_QUAL;
                            cnt_n = ONE;
                        end
                    end
                end
                ST_QUAL: begin
                    if (line_s) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else if (od_mode || cnt_q == flt_last) begin
                        accept = 1'b1;
                        st_n   = ST_LOW;
                        cnt_n  = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                ST_LOW: begin
                    if (line_s) begin
                        st_n  = ST_HOLD;
                        cnt_n = '0;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q >= hold_last) begin
                        cnt_n = '0;
                        if (!line_s) begin
                            accept = 1'b1;
                            st_n   = ST_LOW;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_clean <= 1'b1;
            slot_start <= 1'b0;
        end else begin
            line_clean <= (st_n != ST_LOW);
            slot_start <= accept;
        end
    end

endmodule

// File: rtl/swire_edge_filter.sv
module swire_edge_filter
    import swef_pkg::*;
#(
    parameter int FLT_STD  = 4,
    parameter int HOLD_STD = 8,
    parameter int HOLD_OD  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic od_mode,
    input  logic line_raw,
    output logic line_clean,
    output logic slot_start
);

    localparam int MAXLEN = swef_max3(FLT_STD, HOLD_STD, HOLD_OD);
    localparam int CW     = $clog2(MAXLEN + 1);

    logic          line_s;
    logic [CW-1:0] flt_last;
    logic [CW-1:0] hold_last;

    swef_sync #(
        .STAGES   (SYNC_STAGES),
        .RST_LEVEL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (line_raw),
        .d_out(line_s)
    );

    swef_limits #(
        .FLT_STD (FLT_STD),
        .HOLD_STD(HOLD_STD),
        .HOLD_OD (HOLD_OD),
        .CW      (CW)
    ) u_lim (
        .od_mode  (od_mode),
        .flt_last (flt_last),
        .hold_last(hold_last)
    );

    swef_fsm #(
        .CW(CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .od_mode   (od_mode),
        .line_s    (line_s),
        .flt_last  (flt_last),
        .hold_last (hold_last),
        .line_clean(line_clean),
        .slot_start(slot_start)
    );

endmodule

// File: rtl/swef_checker.sv
module swef_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic line_clean,
    input logic slot_start
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start); // R8

    AST_STROBE_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> !line_clean); // R4

    AST_FALL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_clean) |-> slot_start); // R4

    AST_NO_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!slot_start && $stable(line_clean))); // R9

    AST_RISE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_clean) |=> !slot_start); // R5

endmodule

bind swire_edge_filter swef_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .line_clean(line_clean),
    .slot_start(slot_start)
);

// File: tb/swire_edge_filter_test.sv
module swire_edge_filter_test;

    localparam int F   = 4;
    localparam int HS  = 8;
    localparam int HO  = 3;
    localparam int WDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic od_mode = 1'b0;
    logic line_raw = 1'b1;
    logic line_clean;
    logic slot_start;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_strobe = 0;
    bit done = 1'b0;

    int    exp_cyc[$];
    string exp_req[$];

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    swire_edge_filter #(
        .FLT_STD(F), .HOLD_STD(HS), .HOLD_OD(HO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .od_mode(od_mode),
        .line_raw(line_raw), .line_clean(line_clean), .slot_start(slot_start)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int c, string req);
        exp_cyc.push_back(c);
        exp_req.push_back(req);
    endtask

    // Low pulse of len cycles; exp_off < 0 means no strobe expected
    task automatic pulse(int len, int exp_off, string req);
        if (exp_off >= 0) expect_at(cyc + exp_off, req);
        line_raw = 1'b0;
        gap(len);
        line_raw = 1'b1;
    endtask

    task automatic check_count(int snap, int delta, string req);
        chk(n_strobe - snap == delta, req, n_strobe - snap, delta);
    endtask

    // Monitor: compares strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && slot_start) begin
            n_strobe++;
            if (exp_cyc.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", cyc, -1);
            end else begin
                int c;
                string r;
                c = exp_cyc.pop_front();
                r = exp_req.pop_front();
                chk(c == cyc, r, cyc, c);
            end
        end
    end

    initial begin
        #(WDOG * 8);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int snap;
        int r;
        gap(3);
        // R1: reset state
        chk(line_clean == 1'b1, "R1 clean in reset", line_clean, 1);
        chk(slot_start == 1'b0, "R1 strobe in reset", slot_start, 0);
        rst_n = 1'b1;
        gap(5);
        chk(line_clean == 1'b1, "R1 clean after reset", line_clean, 1);
        check_count(0, 0, "R1 no strobe after reset");

        // R2: short standard-speed low rejected
        snap = n_strobe;
        pulse(F - 1, -1, "");
        gap(20);
        check_count(snap, 0, "R2 short low ignored");
        chk(line_clean == 1'b1, "R2 clean after short low", line_clean, 1);

        // R2 R8: minimum-length low accepted once
        snap = n_strobe;
        pulse(F, F + 2, "R2 accept latency");
        gap(25);
        check_count(snap, 1, "R8 one strobe per edge");

        // R4 R5: long low, then glitch inside hold-off
        snap = n_strobe;
        expect_at(cyc + F + 2, "R2 long low");
        line_raw = 1'b0;
        gap(8);
        chk(line_clean == 1'b0, "R4 clean low while held", line_clean, 0);
        line_raw = 1'b1;
        r = cyc;
        gap(2);
        chk(line_clean == 1'b0, "R4 clean before rise seen", line_clean, 0);
        gap(1);
        chk(line_clean == 1'b1, "R4 clean after rise", line_clean, 1);
        pulse(2, -1, "");            // lows sampled inside window
        gap(2);
        chk(line_clean == 1'b1, "R5 clean during glitch", line_clean, 1);
        gap(20);
        check_count(snap, 1, "R5 glitch in window ignored");

        // R6: low starting in window, still low at its end (standard)
        snap = n_strobe;
        expect_at(cyc + F + 2, "R2 entry");
        line_raw = 1'b0;
        gap(8);
        line_raw = 1'b1;
        r = cyc;
        gap(4);
        expect_at(r + HS + 3, "R6 late low standard");
        line_raw = 1'b0;
        gap(12);
        line_raw = 1'b1;
        gap(25);
        check_count(snap, 2, "R6 standard count");

        // R7: after expiry, standard filtering applies again
        pulse(F, F + 2, "R7 standard after window");
        gap(25);

        // R3 R10: overdrive single low sample accepted after sync delay
        od_mode = 1'b1;
        gap(3);
        snap = n_strobe;
        pulse(1, 3, "R3 R10 overdrive latency");
        gap(1);
        pulse(1, -1, "");            // glitch inside overdrive window
        gap(20);
        check_count(snap, 1, "R5 overdrive glitch ignored");

        // R6: overdrive late low
        snap = n_strobe;
        expect_at(cyc + 3, "R3 entry");
        line_raw = 1'b0;
        gap(3);
        line_raw = 1'b1;
        r = cyc;
        gap(1);
        expect_at(r + HO + 3, "R6 late low overdrive");
        line_raw = 1'b0;
        gap(8);
        line_raw = 1'b1;
        gap(20);
        check_count(snap, 2, "R6 overdrive count");

        // R7: overdrive after expiry, one-cycle low accepted
        pulse(1, 3, "R7 overdrive after window");
        gap(20);

        // R9: tick held low freezes the filter
        od_mode = 1'b0;
        gap(3);
        tick = 1'b0;
        snap = n_strobe;
        pulse(10, -1, "");
        gap(5);
        chk(line_clean == 1'b1, "R9 clean frozen", line_clean, 1);
        tick = 1'b1;
        gap(20);
        check_count(snap, 0, "R9 no strobe without tick");

        chk(exp_cyc.size() == 0, "R8 missing strobes", exp_cyc.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule